// File: doc/BRIEF.md
# Sampling Converter Host Bus Controller

This block models the digital side of a 14-bit sampling converter as seen from a host processor bus. It decides when a conversion begins, keeps an internal timer running for a fixed number of master clock cycles while the input is held, latches the held sample as the result when the timer expires, and presents that result on a parallel bus during host reads. The analog converter, the track-and-hold and any serial output are outside the block; the `sample_in` port stands in for the value the track-and-hold would freeze.

Two start schemes are selectable with `csel_mode`. With `csel_mode` low, a separate active-low strobe `start_n` launches conversion on its rising edge, and the shared status pin `stat_n` acts as an interrupt: it drops when a result is ready and is released by the next host read. With `csel_mode` high, `start_n` is tied low and a chip-select falling edge with `hbyte_sel` low launches conversion; `stat_n` then acts as a busy line that holds the host in a wait state, so the block looks like slow memory. Results can be read as one 14-bit word or as two bytes chosen by `hbyte_sel`.

Misuse, meaning a second start or an interfering read while a conversion runs, sets a sticky `proto_err` flag; the extra start is ignored and the running conversion finishes on its original schedule with its original sample.

Top module: `sconv_bus_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released, `bus_oe`, `hold` and `proto_err` are 0, and `stat_n` is 0 when `csel_mode` is 0 (a result flag pending from power-up, parameter `PWRUP_IRQ` = 1) or 1 when `csel_mode` is 1.
- R2: With `csel_mode` = 0 and no conversion running, a rising edge of `start_n` sampled at clock edge E starts a conversion; `stat_n` stays 1 through edge E+CONV_CYCLES-1 and is 0 after edge E+CONV_CYCLES.
- R3: With `csel_mode` = 0, the first clock edge that samples `cs_n` and `rd_n` both low after a cycle where they were not both low returns `stat_n` to 1, including the single dummy read that clears the power-up flag; holding the access longer has no further effect.
- R4: With `csel_mode` = 1 and no conversion running, a falling edge of `cs_n` sampled with `hbyte_sel` = 0 at edge E starts a conversion, `stat_n` is 0 after edges E through E+CONV_CYCLES-1 and 1 after edge E+CONV_CYCLES; a `cs_n` fall with `hbyte_sel` = 1 starts nothing.
- R5: `hold` is 1 for exactly the CONV_CYCLES cycles of a conversion, and the result is the `sample_in` value seen at the starting edge, whatever `sample_in` does afterwards.
- R6: With `byte_fmt` = 0, a read drives all 14 result bits on `bus_q`.
- R7: With `byte_fmt` = 1, a read with `hbyte_sel` = 0 drives result bits 7..0 on `bus_q[7:0]`; with `hbyte_sel` = 1 it drives result bits 13..8 on `bus_q[5:0]` with `bus_q[7:6]` zero; `bus_q[13:8]` is zero in both cases.
- R8: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low; `bus_q` is zero whenever `bus_oe` is 0.
- R9: A start request during a conversion (a `start_n` rise with `csel_mode` = 0, a `cs_n` fall with `csel_mode` = 1) sets `proto_err` and does not change the end time or the result of the running conversion.
- R10: With `csel_mode` = 0, a read access that begins during a conversion sets `proto_err`.
- R11: With `csel_mode` = 0, when a read access begins at the same edge at which a conversion ends, the end wins: `stat_n` goes to 0 and stays 0 while that access is held, and `proto_err` is set.
- R12: Once set, `proto_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| csel_mode | input | 1 | 0: strobe start with interrupt status; 1: chip-select start with busy status |
| byte_fmt | input | 1 | 0: 14-bit word reads; 1: byte reads |
| start_n | input | 1 | Active-low start strobe, conversion begins on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| hbyte_sel | input | 1 | Selects the high byte in byte format; must be low for a chip-select start |
| sample_in | input | 14 | Value frozen by the hold at conversion start |
| stat_n | output | 1 | Interrupt (strobe mode) or busy (chip-select mode), active low |
| hold | output | 1 | High while the sample is held and the conversion runs |
| bus_q | output | 14 | Parallel read data, zero when not enabled |
| bus_oe | output | 1 | Bus drive enable; high stands for driven, low for high impedance |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The interesting overlap is the end of a conversion landing on the same clock edge as the start of a host read in strobe mode, where the edge that raises the interrupt also sees the access that would clear it. The bench times the read so that its first low sample coincides with the final timer edge, then expects `stat_n` low with `proto_err` set, `stat_n` still low on the following cycle while the read is held, and high only after a fresh read.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

    localparam int RES_W  = 14;
    localparam int BYTE_W = 8;
    localparam int HI_W   = RES_W - BYTE_W;

    typedef logic [RES_W-1:0] word_t;

    typedef enum logic {
        START_STROBE = 1'b0,
        START_CSEL   = 1'b1
    } start_mode_e;

    // Qualified bus events for one clock cycle
    typedef struct packed {
        logic launch_req;    // request that would start a conversion
        logic conflict_req;  // request that is illegal while converting
        logic acc_fall;      // a read access has just opened
    } evt_t;

    // Place the result on the bus in the selected format
    function automatic word_t pack_bus(word_t w, logic byte_fmt, logic hi);
        word_t o;
        o = '0;
        if (!byte_fmt)
            o = w;
        else if (hi)
            o[HI_W-1:0] = w[RES_W-1:BYTE_W];
        else
            o[BYTE_W-1:0] = w[BYTE_W-1:0];
        return o;
    endfunction

endpackage

// File: rtl/sconv_evt.sv
module sconv_evt
    import sconv_pkg::*;
(
    input  logic        clk,
    input  start_mode_e mode,
    input  logic        start_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        hbyte_sel,
    output evt_t        evt
);

    logic start_n_q;
    logic cs_n_q;
    logic acc_q;
    logic acc;
    logic strobe_rise;
    logic cs_fall;

    assign acc = ~cs_n & ~rd_n;

    // Previous-cycle samples for edge detection
    always_ff @(posedge clk) begin
        start_n_q <= start_n;
        cs_n_q    <= cs_n;
        acc_q     <= acc;
    end

    assign strobe_rise = start_n & ~start_n_q;
    assign cs_fall     = cs_n_q & ~cs_n;

    always_comb begin
        evt.acc_fall = acc & ~acc_q;
        if (mode == START_CSEL) begin
            evt.launch_req   = cs_fall & ~hbyte_sel;
            evt.conflict_req = cs_fall;
        end else begin
            evt.launch_req   = strobe_rise;
            evt.conflict_req = strobe_rise | evt.acc_fall;
        end
    end

endmodule

// File: rtl/sconv_timer.sv
module sconv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic active,
    output logic done
);

    localparam int CW = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST)
                active <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign done = active & (cnt == LAST);

endmodule

// File: rtl/sconv_status.sv
module sconv_status
    import sconv_pkg::*;
#(
    parameter logic PWRUP_IRQ = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  start_mode_e mode,
    input  logic        active,
    input  logic        done,
    input  logic        acc_fall,
    input  logic        conflict_req,
    output logic        stat_n,
    output logic        proto_err
);

    logic irq_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend  <= PWRUP_IRQ;
            proto_err <= 1'b0;
        end else begin
            // End of conversion outranks a read opening at the same edge
            if (done && mode == START_STROBE)
                irq_pend <= 1'b1;
            else if (acc_fall)
                irq_pend <= 1'b0;
            if (active && conflict_req)
                proto_err <= 1'b1;
        end
    end

    assign stat_n = (mode == START_CSEL) ? ~active : ~irq_pend;

endmodule

// File: rtl/sconv_busmux.sv
module sconv_busmux
    import sconv_pkg::*;
(
    input  word_t result,
    input  logic  byte_fmt,
    input  logic  hbyte_sel,
    input  logic  cs_n,
    input  logic  rd_n,
    output word_t bus_q,
    output logic  bus_oe
);

    assign bus_oe = ~cs_n & ~rd_n;
    assign bus_q  = bus_oe ? pack_bus(result, byte_fmt, hbyte_sel) : '0;

endmodule

// File: rtl/sconv_bus_ctrl.sv
module sconv_bus_ctrl
    import sconv_pkg::*;
#(
    parameter int   CONV_CYCLES = 20,
    parameter logic PWRUP_IRQ   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csel_mode,
    input  logic             byte_fmt,
    input  logic             start_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hbyte_sel,
    input  logic [RES_W-1:0] sample_in,
    output logic             stat_n,
    output logic             hold,
    output logic [RES_W-1:0] bus_q,
    output logic             bus_oe,
    output logic             proto_err
);

    start_mode_e mode;
    evt_t        evt;
    logic        launch;
    logic        active;
    logic        done;
    word_t       held_word;
    word_t       result;

    assign mode = start_mode_e'(csel_mode);

    sconv_evt u_evt (
        .clk       (clk),
        .mode      (mode),
        .start_n   (start_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hbyte_sel (hbyte_sel),
        .evt       (evt)
    );

    // A start request is honoured only when idle
    assign launch = evt.launch_req & ~active;

    sconv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .active (active),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= '0;
            result    <= '0;
        end else begin
            if (launch)
                held_word <= sample_in;
            if (done)
                result <= held_word;
        end
    end

    sconv_status #(.PWRUP_IRQ(PWRUP_IRQ)) u_status (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .active       (active),
        .done         (done),
        .acc_fall     (evt.acc_fall),
        .conflict_req (evt.conflict_req),
        .stat_n       (stat_n),
        .proto_err    (proto_err)
    );

    sconv_busmux u_mux (
        .result    (result),
        .byte_fmt  (byte_fmt),
        .hbyte_sel (hbyte_sel),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .bus_q     (bus_q),
        .bus_oe    (bus_oe)
    );

    assign hold = active;

endmodule

// File: rtl/sconv_chk.sv
module sconv_chk #(
    parameter int CONV_CYCLES = 20
) (
    input logic clk,
    input logic rst,
    input logic csel_mode,
    input logic start_n,
    input logic cs_n,
    input logic rd_n,
    input logic stat_n,
    input logic hold,
    input logic proto_err
);

    logic [31:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst || !hold)
            hold_run <= '0;
        else
            hold_run <= hold_run + 1;
    end

    AST_HOLD_LEN_MAX: assert property (@(posedge clk) disable iff (rst)
        hold |-> (hold_run < CONV_CYCLES)); // R5

    AST_STROBE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!csel_mode && !hold && $rose(start_n)) |=> hold); // R2

    AST_INT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (!csel_mode && $fell(hold)) |-> !stat_n); // R2

    AST_BUSY_DURING_HOLD: assert property (@(posedge clk) disable iff (rst)
        (csel_mode && hold) |-> !stat_n); // R4

    AST_READ_RELEASES_INT: assert property (@(posedge clk) disable iff (rst)
        (!csel_mode && !hold && !stat_n && !cs_n && !rd_n && !$past(!cs_n && !rd_n))
        |=> stat_n); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R12

endmodule

bind sconv_bus_ctrl sconv_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csel_mode (csel_mode),
    .start_n   (start_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .stat_n    (stat_n),
    .hold      (hold),
    .proto_err (proto_err)
);

// File: tb/sconv_bus_ctrl_tb.sv
module sconv_bus_ctrl_tb;

    localparam int N = 20;

    localparam int F_STAT = 0;
    localparam int F_OE   = 1;
    localparam int F_BUS  = 2;
    localparam int F_ERR  = 3;
    localparam int F_HOLD = 4;

    typedef struct {
        int          due;
        int          fld;
        logic [13:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csel_mode = 1'b0;
    logic        byte_fmt = 1'b0;
    logic        start_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hbyte_sel = 1'b0;
    logic [13:0] sample_in = '0;
    logic        stat_n;
    logic        hold;
    logic [13:0] bus_q;
    logic        bus_oe;
    logic        proto_err;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    sconv_bus_ctrl #(.CONV_CYCLES(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .csel_mode (csel_mode),
        .byte_fmt  (byte_fmt),
        .start_n   (start_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hbyte_sel (hbyte_sel),
        .sample_in (sample_in),
        .stat_n    (stat_n),
        .hold      (hold),
        .bus_q     (bus_q),
        .bus_oe    (bus_oe),
        .proto_err (proto_err)
    );

    function automatic logic [13:0] observe(int f);
        case (f)
            F_STAT:  return {13'b0, stat_n};
            F_OE:    return {13'b0, bus_oe};
            F_BUS:   return bus_q;
            F_ERR:   return {13'b0, proto_err};
            default: return {13'b0, hold};
        endcase
    endfunction

    // Monitor: one cycle count per edge, compare everything due now
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic [13:0] got;
                    got = observe(sb[i].fld);
                    n_checks++;
                    if (got !== sb[i].val) begin
                        n_fails++;
                        $display("FAIL %s cycle %0d field %0d: got %h expected %h",
                                 sb[i].tag, cyc, sb[i].fld, got, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    // Driver side: queue an expectation dly cycles from the current count
    task automatic expect_at(int dly, int f, logic [13:0] v, string tag);
        exp_t e;
        e.due = cyc + dly;
        e.fld = f;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    // Strobe start; returns the count at the negedge where start_n rises
    task automatic strobe_start(logic [13:0] v, output int base);
        sample_in = v;
        start_n   = 1'b0;
        step(1);
        start_n = 1'b1;
        base    = cyc;
    endtask

    // One read access of one cycle, checking bus and status
    task automatic read_once(logic fmt, logic hb, logic [13:0] want, string tag);
        byte_fmt  = fmt;
        hbyte_sel = hb;
        cs_n      = 1'b0;
        rd_n      = 1'b0;
        expect_at(1, F_BUS, want, tag);
        expect_at(1, F_OE, 14'd1, "R8");
        step(1);
        cs_n = 1'b1;
        rd_n = 1'b1;
        expect_at(1, F_OE, 14'd0, "R8");
        expect_at(1, F_BUS, 14'd0, "R8");
        step(1);
    endtask

    initial begin
        int b;

        // Reset, strobe mode: power-up flag pending
        step(3);
        rst = 1'b0;
        expect_at(1, F_STAT, 14'd0, "R1");
        expect_at(1, F_OE,   14'd0, "R1");
        expect_at(1, F_ERR,  14'd0, "R1");
        expect_at(1, F_HOLD, 14'd0, "R1");
        step(2);

        // Dummy read clears the flag; holding the access changes nothing
        cs_n = 1'b0;
        rd_n = 1'b0;
        expect_at(1, F_STAT, 14'd1, "R3");
        expect_at(1, F_OE,   14'd1, "R8");
        expect_at(2, F_STAT, 14'd1, "R3");
        step(2);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(2);

        // Strobe conversion, full-width read
        strobe_start(14'h2A5C, b);
        expect_at(1,     F_HOLD, 14'd1, "R5");
        expect_at(N,     F_STAT, 14'd1, "R2");
        expect_at(N,     F_HOLD, 14'd1, "R5");
        expect_at(N + 1, F_STAT, 14'd0, "R2");
        expect_at(N + 1, F_HOLD, 14'd0, "R5");
        step(2);
        sample_in = 14'h0000;
        step(N + 1);
        expect_at(1, F_STAT, 14'd1, "R3");
        read_once(1'b0, 1'b0, 14'h2A5C, "R6");

        // Byte reads of the same result
        read_once(1'b1, 1'b0, 14'h005C, "R7");
        read_once(1'b1, 1'b1, 14'h002A, "R7");

        // Second strobe during conversion
        strobe_start(14'h1111, b);
        expect_at(3,     F_ERR,  14'd0, "R9");
        expect_at(7,     F_ERR,  14'd1, "R9");
        expect_at(N,     F_STAT, 14'd1, "R9");
        expect_at(N + 1, F_STAT, 14'd0, "R9");
        step(4);
        sample_in = 14'h3FFF;
        start_n   = 1'b0;
        step(1);
        start_n = 1'b1;
        step(N);
        read_once(1'b0, 1'b0, 14'h1111, "R9");
        expect_at(3, F_ERR, 14'd1, "R12");
        step(4);

        // Read during a strobe conversion
        do_reset();
        step(1);
        cs_n = 1'b0;
        rd_n = 1'b0;
        step(1);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(1);
        strobe_start(14'h0777, b);
        expect_at(3, F_ERR, 14'd0, "R10");
        step(3);
        cs_n = 1'b0;
        rd_n = 1'b0;
        expect_at(1, F_ERR, 14'd1, "R10");
        step(1);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(N);
        read_once(1'b0, 1'b0, 14'h0777, "R10");

        // Read opens on the very edge that ends the conversion
        do_reset();
        step(1);
        cs_n = 1'b0;
        rd_n = 1'b0;
        step(1);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(1);
        strobe_start(14'h0ABC, b);
        step(N);
        cs_n = 1'b0;
        rd_n = 1'b0;
        expect_at(1, F_STAT, 14'd0, "R11");
        expect_at(1, F_ERR,  14'd1, "R11");
        expect_at(2, F_STAT, 14'd0, "R11");
        step(2);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(1);
        expect_at(1, F_STAT, 14'd1, "R11");
        read_once(1'b0, 1'b0, 14'h0ABC, "R11");

        // Chip-select start mode, byte reads
        csel_mode = 1'b1;
        start_n   = 1'b0;
        do_reset();
        expect_at(1, F_STAT, 14'd1, "R1");
        expect_at(1, F_ERR,  14'd0, "R12");
        step(2);
        sample_in = 14'h3ABC;
        byte_fmt  = 1'b1;
        hbyte_sel = 1'b0;
        cs_n      = 1'b0;
        rd_n      = 1'b0;
        expect_at(1,     F_STAT, 14'd0, "R4");
        expect_at(1,     F_HOLD, 14'd1, "R5");
        expect_at(N,     F_STAT, 14'd0, "R4");
        expect_at(N + 1, F_STAT, 14'd1, "R4");
        expect_at(N + 1, F_BUS,  14'h00BC, "R7");
        expect_at(N + 1, F_ERR,  14'd0, "R4");
        step(2);
        sample_in = 14'h0001;
        step(N);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(1);
        hbyte_sel = 1'b1;
        cs_n      = 1'b0;
        rd_n      = 1'b0;
        expect_at(1, F_BUS,  14'h003A, "R7");
        expect_at(2, F_STAT, 14'd1, "R4");
        expect_at(2, F_HOLD, 14'd0, "R4");
        step(2);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(1);

        // Chip-select mode, full width, extra start mid conversion
        byte_fmt  = 1'b0;
        hbyte_sel = 1'b0;
        sample_in = 14'h1F0F;
        cs_n      = 1'b0;
        rd_n      = 1'b0;
        expect_at(N,     F_STAT, 14'd0, "R9");
        expect_at(N + 1, F_STAT, 14'd1, "R9");
        expect_at(7,     F_ERR,  14'd1, "R9");
        expect_at(4,     F_ERR,  14'd0, "R9");
        step(3);
        cs_n = 1'b1;
        rd_n = 1'b1;
        step(2);
        sample_in = 14'h2222;
        cs_n      = 1'b0;
        step(1);
        cs_n = 1'b1;
        step(N);
        read_once(1'b0, 1'b0, 14'h1F0F, "R6");
        expect_at(1, F_ERR, 14'd1, "R12");
        step(2);

        // Final reset clears the sticky flag
        do_reset();
        expect_at(1, F_ERR, 14'd0, "R12");
        step(4);

        wait (sb.size() == 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule